// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block does lane-wise arithmetic on a data word. The word is split into either two halfword lanes or four byte lanes. Each operation adds or subtracts lane by lane, or uses one of the two exchange forms. In an exchange form the upper lane of one operand is paired with the lower lane of the other. A further operation builds the result byte by byte from the two operands. It picks each byte using four stored greater-or-equal flags.

A three-bit mode input chooses how lanes are treated and what happens to a result that leaves the lane's range:
- signed or unsigned lanes;
- the result wraps, is clamped at the lane limits, or is the full-precision value halved.

The result is combinational from the operands, the operation, the mode and the stored flags. The flags sit in a four-bit register. Only a valid truncating add or subtract loads it. A caller typically issues a truncating compare-style operation first, then a byte pick that uses the flags it left behind.

The byte width is a parameter. The halfword and word widths follow from it.

Top module: `packed_simd_au`

## Requirements
- R1: While reset is low, the flag output `ge_o` is 0000.
- R2: With mode 0 (signed wrap) or mode 4 (unsigned wrap), each lane result is the lane sum or difference modulo 2^lane-width, and lanes never affect one another. The operation codes are: 0 halfword add, 3 halfword subtract, 4 byte add, 5 byte subtract. Byte n is bits 8n+7..8n and halfword n is bits 16n+15..16n.
- R3: With mode 1 (signed clamp), a lane result outside [-2^(w-1), 2^(w-1)-1] becomes the nearer limit. With mode 5 (unsigned clamp), a lane result outside [0, 2^w-1] becomes the nearer limit.
- R4: With mode 2 (signed halve) or mode 6 (unsigned halve), the lane result is the full-precision sum or difference shifted right by one. The shift is arithmetic in mode 2. No overflow can occur.
- R5: Operation 1 gives upper = a.upper + b.lower and lower = a.lower - b.upper on halfword lanes.
- R6: Operation 2 gives upper = a.upper - b.lower and lower = a.lower + b.upper on halfword lanes.
- R7: After a valid operation in mode 0, each lane's flag is 1 exactly when the full-precision signed lane result is zero or positive.
- R8: After a valid operation in mode 4, an add lane's flag is 1 exactly on a carry out of the lane. A subtract lane's flag is 1 exactly when no borrow occurs.
- R9: In halfword operations with a wrap mode, lane 0 drives flag bits 1 and 0, and lane 1 drives flag bits 3 and 2.
- R10: The flags keep their value in these cases: after a valid operation in a clamp or halve mode, after operation 6, and in any cycle with `op_valid_i` low.
- R11: Operation 6 (byte pick) sets result byte n to byte n of `a_i` when flag n is 1, and otherwise to byte n of `b_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 3 | Operation code (0..6; 7 behaves as 6) |
| mode_i | input | 3 | Bit 2 selects unsigned. Bits 1..0: 0 wrap, 1 clamp, 2 halve (3 behaves as wrap) |
| a_i | input | 4*BYTE_W | First operand |
| b_i | input | 4*BYTE_W | Second operand |
| res_o | output | 4*BYTE_W | Packed result |
| ge_o | output | 4 | Stored greater-or-equal flags |

## Verification
Every arithmetic operation is run in each of the six modes against a fixed set of lane-boundary words. These words include all zeros, all ones, the most negative and most positive halfword and byte, and alternating patterns. A pseudo-random stream then fills in ordinary values. The boundary pairs separate wrap from clamp from halve, and signed from unsigned flag rules. They also show a carry leaking between lanes, or a byte result masquerading as a halfword one.

Each operation is followed by a byte pick. The pick shows whether the flags were loaded or held, and confirms that byte selection follows the flag bits.

// File: rtl/psau_pkg.sv
package psau_pkg;

   typedef enum logic [2:0] {
      OPC_ADD16    = 3'd0,
      OPC_XAS      = 3'd1,
      OPC_XSA      = 3'd2,
      OPC_SUB16    = 3'd3,
      OPC_ADD8     = 3'd4,
      OPC_SUB8     = 3'd5,
      OPC_PICK     = 3'd6,
      OPC_PICK_ALT = 3'd7
   } psau_op_e;

   localparam logic [1:0] KIND_WRAP   = 2'd0;
   localparam logic [1:0] KIND_SAT    = 2'd1;
   localparam logic [1:0] KIND_HALVE  = 2'd2;
   localparam logic [1:0] KIND_WRAP_R = 2'd3;

endpackage

// File: rtl/psau_lane.sv
module psau_lane
   import psau_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         sub_i,
   input  logic         uns_i,
   input  logic [1:0]   kind_i,
   output logic [W-1:0] res_o,
   output logic         ge_o
);
   localparam int EW = W + 2;
   localparam logic signed [EW-1:0] SMAX = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [EW-1:0] SMIN = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};
   localparam logic signed [EW-1:0] UMAX = {2'b00, {W{1'b1}}};

   logic signed [EW-1:0] ex, ey, sum;

   always_comb begin
      ex  = uns_i ? {2'b00, x_i} : {{2{x_i[W-1]}}, x_i};
      ey  = uns_i ? {2'b00, y_i} : {{2{y_i[W-1]}}, y_i};
      sum = sub_i ? (ex - ey) : (ex + ey);
   end

   always_comb begin
      unique case (kind_i)
         KIND_SAT: begin
            if (uns_i) begin
               if (sum[EW-1])      res_o = '0;
               else if (sum > UMAX) res_o = '1;
               else                 res_o = sum[W-1:0];
            end else begin
               if (sum > SMAX)      res_o = SMAX[W-1:0];
               else if (sum < SMIN) res_o = SMIN[W-1:0];
               else                 res_o = sum[W-1:0];
            end
         end
         KIND_HALVE: res_o = sum[W:1];
         default:    res_o = sum[W-1:0];
      endcase
   end

   assign ge_o = (uns_i && !sub_i) ? sum[W] : ~sum[EW-1];

endmodule

// File: rtl/psau_select.sv
module psau_select #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic [LANES*BYTE_W-1:0] a_i,
   input  logic [LANES*BYTE_W-1:0] b_i,
   input  logic [LANES-1:0]        ge_i,
   output logic [LANES*BYTE_W-1:0] res_o
);
   for (genvar n = 0; n < LANES; n++) begin : g_pick
      assign res_o[n*BYTE_W +: BYTE_W] = ge_i[n] ? a_i[n*BYTE_W +: BYTE_W]
                                                 : b_i[n*BYTE_W +: BYTE_W];
   end
endmodule

// File: rtl/packed_simd_au.sv
module packed_simd_au
   import psau_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid_i,
   input  logic [2:0]          op_i,
   input  logic [2:0]          mode_i,
   input  logic [4*BYTE_W-1:0] a_i,
   input  logic [4*BYTE_W-1:0] b_i,
   output logic [4*BYTE_W-1:0] res_o,
   output logic [3:0]          ge_o
);
   localparam int LANES  = 4;
   localparam int HALF_W = 2 * BYTE_W;
   localparam int WORD_W = LANES * BYTE_W;

   if (BYTE_W < 2 || BYTE_W > 15) begin : g_bad_width
      $error("packed_simd_au: BYTE_W must lie in 2..15");
   end

   psau_op_e          op;
   logic [1:0]        kind;
   logic              is_half, is_byte, is_pick, is_wrap, exch;
   logic [WORD_W-1:0] bres, hres, pres;
   logic [LANES-1:0]  bge, ge_nxt, ge_q;
   logic [1:0]        hge, hsub;
   logic [HALF_W-1:0] hx [2];
   logic [HALF_W-1:0] hy [2];

   assign op      = psau_op_e'(op_i);
   assign kind    = mode_i[1:0];
   assign is_half = (op_i[2] == 1'b0);
   assign is_byte = (op == OPC_ADD8) || (op == OPC_SUB8);
   assign is_pick = (op == OPC_PICK) || (op == OPC_PICK_ALT);
   assign is_wrap = (kind == KIND_WRAP) || (kind == KIND_WRAP_R);
   assign exch    = (op == OPC_XAS) || (op == OPC_XSA);

   // byte lanes
   for (genvar n = 0; n < LANES; n++) begin : g_byte
      psau_lane #(.W(BYTE_W)) u_lane (
         .x_i   (a_i[n*BYTE_W +: BYTE_W]),
         .y_i   (b_i[n*BYTE_W +: BYTE_W]),
         .sub_i (op == OPC_SUB8),
         .uns_i (mode_i[2]),
         .kind_i(kind),
         .res_o (bres[n*BYTE_W +: BYTE_W]),
         .ge_o  (bge[n])
      );
   end

   // halfword lane operand steering, exchange forms cross the second operand
   always_comb begin
      hx[0]   = a_i[HALF_W-1:0];
      hx[1]   = a_i[WORD_W-1:HALF_W];
      hy[0]   = exch ? b_i[WORD_W-1:HALF_W] : b_i[HALF_W-1:0];
      hy[1]   = exch ? b_i[HALF_W-1:0]      : b_i[WORD_W-1:HALF_W];
      hsub[0] = (op == OPC_XAS) || (op == OPC_SUB16);
      hsub[1] = (op == OPC_XSA) || (op == OPC_SUB16);
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      psau_lane #(.W(HALF_W)) u_lane (
         .x_i   (hx[h]),
         .y_i   (hy[h]),
         .sub_i (hsub[h]),
         .uns_i (mode_i[2]),
         .kind_i(kind),
         .res_o (hres[h*HALF_W +: HALF_W]),
         .ge_o  (hge[h])
      );
   end

   psau_select #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pick (
      .a_i  (a_i),
      .b_i  (b_i),
      .ge_i (ge_q),
      .res_o(pres)
   );

   always_comb begin
      if (is_pick)      res_o = pres;
      else if (is_byte) res_o = bres;
      else              res_o = hres;
   end

   assign ge_nxt = is_half ? {hge[1], hge[1], hge[0], hge[0]} : bge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ge_q <= '0;
      else if (op_valid_i && is_wrap && !is_pick)
         ge_q <= ge_nxt;
   end

   assign ge_o = ge_q;

   // ---------------- assertions ----------------
   AST_FLAGS_RESET: assert property (@(posedge clk) !rst_n |=> (ge_o == 4'b0000)); // R1

   AST_NOWRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && !is_wrap) |=> $stable(ge_o)); // R10

   AST_PICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && is_pick) |=> $stable(ge_o)); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> $stable(ge_o)); // R10

   AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && is_wrap && is_half) |=> (ge_o[0] == ge_o[1] && ge_o[2] == ge_o[3])); // R9

   for (genvar n = 0; n < LANES; n++) begin : g_chk
      AST_HALVE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
         (is_byte && kind == KIND_HALVE && !mode_i[2])
            |-> (bres[n*BYTE_W + BYTE_W-1] == !bge[n])); // R4
      AST_PICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         is_pick |-> (res_o[n*BYTE_W +: BYTE_W] == (ge_o[n] ? a_i[n*BYTE_W +: BYTE_W]
                                                           : b_i[n*BYTE_W +: BYTE_W]))); // R11
   end

endmodule

// File: tb/packed_simd_au_tb.sv
module packed_simd_au_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [2:0]  mode_i = 3'd0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic [31:0] res_o;
   logic [3:0]  ge_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [3:0] exp_ge = 4'b0000;
   logic [31:0] lfsr = 32'hACE1_2468;

   packed_simd_au #(.BYTE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
      .mode_i(mode_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .ge_o(ge_o)
   );

   always #4 clk = ~clk;

   function automatic logic [15:0] lane_ref(input logic [15:0] x, input logic [15:0] y,
                                            input int w, input bit sub, input bit uns,
                                            input int kind, output bit ge);
      longint xs, ys, s, r, one;
      one = 1;
      xs = longint'(x);
      ys = longint'(y);
      if (!uns) begin
         if (xs >= (one << (w-1))) xs = xs - (one << w);
         if (ys >= (one << (w-1))) ys = ys - (one << w);
      end
      s = sub ? xs - ys : xs + ys;
      if (uns && !sub) ge = (s >= (one << w));
      else             ge = (s >= 0);
      if (kind == 1) begin
         if (uns) r = (s < 0) ? 0 : (s > (one << w) - 1) ? (one << w) - 1 : s;
         else     r = (s > (one << (w-1)) - 1) ? (one << (w-1)) - 1 :
                      (s < -(one << (w-1))) ? -(one << (w-1)) : s;
      end else if (kind == 2) r = s >>> 1;
      else                    r = s;
      r = r & ((one << w) - 1);
      return r[15:0];
   endfunction

   function automatic logic [31:0] word_ref(input logic [31:0] a, input logic [31:0] b,
                                            input int op, input int mode,
                                            output logic [3:0] g);
      logic [31:0] r;
      logic [15:0] t;
      bit uns, ge0, ge1, s0, s1;
      int kind;
      uns  = mode[2];
      kind = (mode % 4 == 3) ? 0 : mode % 4;
      r = '0;
      g = '0;
      if (op == 4 || op == 5) begin
         for (int n = 0; n < 4; n++) begin
            t = lane_ref({8'h00, a[8*n +: 8]}, {8'h00, b[8*n +: 8]}, 8, op == 5, uns, kind, ge0);
            r[8*n +: 8] = t[7:0];
            g[n] = ge0;
         end
      end else begin
         s1 = (op == 2) || (op == 3);
         s0 = (op == 1) || (op == 3);
         if (op == 1 || op == 2) begin
            r[31:16] = lane_ref(a[31:16], b[15:0],  16, s1, uns, kind, ge1);
            r[15:0]  = lane_ref(a[15:0],  b[31:16], 16, s0, uns, kind, ge0);
         end else begin
            r[31:16] = lane_ref(a[31:16], b[31:16], 16, s1, uns, kind, ge1);
            r[15:0]  = lane_ref(a[15:0],  b[15:0],  16, s0, uns, kind, ge0);
         end
         g = {ge1, ge1, ge0, ge0};
      end
      return r;
   endfunction

   function automatic string res_tag(input int op, input int mode);
      if (mode % 4 == 1) return "R3";
      if (mode % 4 == 2) return "R4";
      if (op == 1)       return "R5";
      if (op == 2)       return "R6";
      return "R2";
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge
   task automatic do_op(input int op, input int mode, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] er;
      logic [3:0]  g;
      string       gt;
      op_valid_i = 1'b1;
      op_i   = op[2:0];
      mode_i = mode[2:0];
      a_i = a;
      b_i = b;
      if (op >= 6) begin
         for (int n = 0; n < 4; n++) er[8*n +: 8] = exp_ge[n] ? a[8*n +: 8] : b[8*n +: 8];
         g = exp_ge;
      end else
         er = word_ref(a, b, op, mode, g);
      #2;
      check(op >= 6 ? "R11" : res_tag(op, mode), res_o, er);
      @(negedge clk);
      op_valid_i = 1'b0;
      if (op >= 6 || mode % 4 == 1 || mode % 4 == 2) gt = (op >= 6) ? "R10 (pick)" : "R10";
      else begin
         exp_ge = g;
         gt = mode[2] ? "R8" : "R7";
         if (op < 4) gt = {gt, " R9"};
      end
      check(gt, {28'h0, ge_o}, {28'h0, exp_ge});
   endtask

   logic [31:0] corners [8];
   int modes [6];

   initial begin
      corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
      corners[2] = 32'h8000_8000; corners[3] = 32'h7FFF_7FFF;
      corners[4] = 32'h8080_8080; corners[5] = 32'h7F7F_7F7F;
      corners[6] = 32'h0101_0101; corners[7] = 32'h00FF_FF00;
      modes[0] = 0; modes[1] = 1; modes[2] = 2;
      modes[3] = 4; modes[4] = 5; modes[5] = 6;

      repeat (3) @(negedge clk);
      check("R1", {28'h0, ge_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int op = 0; op < 6; op++) begin
         for (int mi = 0; mi < 6; mi++) begin
            for (int i = 0; i < 8; i++) begin
               for (int j = 0; j < 8; j++) begin
                  do_op(op, modes[mi], corners[i], corners[j]);
                  do_op(6, 0, 32'hA5A5_A5A5, 32'h5A5A_5A5A);
               end
            end
            for (int k = 0; k < 24; k++) begin
               logic [31:0] ra, rb;
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               ra = lfsr * 32'h9E37_79B1;
               lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
               rb = lfsr ^ 32'h3C6E_F372;
               do_op(op, modes[mi], ra, rb);
               do_op(7, 1, rb, ra);
            end
         end
      end

      // idle cycle with operands that would change the flags: R10
      do_op(5, 4, 32'h0102_0304, 32'h0403_0201);
      op_i = 3'd5; mode_i = 3'd4; a_i = 32'h0403_0201; b_i = 32'h0102_0304;
      op_valid_i = 1'b0;
      @(negedge clk);
      check("R10 (idle)", {28'h0, ge_o}, {28'h0, exp_ge});

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule